// File: doc/BRIEF.md
# Four-Pin GPIO Port Register Bank

This block is the register side of a small general-purpose I/O port. It keeps, for each of four pins, a direction bit, an output latch bit and a read-polarity bit. It also presents the pin levels as a readable byte. A bus agent outside the block selects one of four 8-bit registers by a 2-bit index. It writes through a one-cycle strobe with data and reads by raising a request. The read byte appears on a registered output in the following cycle.

On the pin side the block takes the raw pin levels and passes each through a two-stage synchronizer. It drives a per-pin output value and an active-high output enable. A pin whose direction bit is set is an input, and its driver is released. A pin whose direction bit is clear drives its output latch bit. The output enable is forced low for as long as reset is asserted.

The serial bus protocol, pull-up resistors and drive strength live outside this block. Only bits 3..0 of each register carry state. Bits 7..4 read back as fixed constants.

Top module: `gpio_port_bank`

## Requirements
- R1: In the first cycle after reset, the registers hold these values. Register 3 (direction) is 0xFF and register 1 (output latch) is 0xFF. Register 2 (polarity) is 0x00. Register 0 reads 0xF followed by the synchronized pin nibble.
- R2: While rst_n is low, pin_oe is 0 on every pin.
- R3: For each pin i, pin_oe[i] is the inverse of direction bit i. pin_out[i] equals output latch bit i when the pin is an output and is 0 when the pin is an input. A write lands on the pins in the cycle after the write edge.
- R4: Register 0 reads bits 3..0 as the synchronized pin level XOR polarity bit i. A pin level must be stable for two clock edges before the edge that samples the read request.
- R5: Register 0 reports the pin level for pins configured as outputs as well as for inputs.
- R6: A write to index 0 changes no register. Later reads of indices 1, 2 and 3 are unchanged, and the register 0 read still follows the pins.
- R7: Reading index 1 returns the stored latch bits, even when the pin levels differ from them.
- R8: Bits 7..4 are never stored. They read as 1111 for indices 0, 1 and 3 and as 0000 for index 2, whatever was written there.
- R9: rd_data is loaded on the clock edge that samples rd_req high. It holds its value in every cycle without a request, even while the pins change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | 2 | Register index: 0 input, 1 output latch, 2 polarity, 3 direction |
| wr_en | input | 1 | One-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_req | input | 1 | Read request; result valid the next cycle |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 4 | Raw pin levels |
| pin_out | output | 4 | Pin drive value |
| pin_oe | output | 4 | Pin output enable, high to drive |

## Verification
The pin side is swept over all 256 pairs of direction nibble and latch nibble. This shows that each pin's enable follows its own direction bit and that latch bits never leak onto released pins. The input path is swept over all 256 pairs of pin level and polarity mask, which separates inversion from direct reads bit by bit. Directed cases follow. The latch is read while the pins are held opposite to it, to separate the stored value from the pin level. Index 0 is written and the other registers are then read back. Upper nibbles are written with ones and zeros. Finally the pins are toggled with no read request, to show that the read register holds its value.

// File: rtl/gpio_bank_pkg.sv
// Package: shared register index encoding for the GPIO port register bank.
// Assumes a fixed 2-bit index space of four registers.
package gpio_bank_pkg;

    typedef enum logic [1:0] {
        IDX_PINS = 2'd0,
        IDX_LATCH = 2'd1,
        IDX_POLAR = 2'd2,
        IDX_DIR = 2'd3
    } reg_idx_e;

endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchronizer, one chain per pin.
// Assumes pin levels are asynchronous to clk; the flops reset to 1 (idle pulled-up level).
module gpio_pin_sync #(
    parameter int NUM_PINS = 4,
    parameter int STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic [NUM_PINS-1:0] pin_raw,
    output logic [NUM_PINS-1:0] pin_sync
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic [STAGES-1:0] chain_q;

        // Shift the raw level through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_raw[g]};
            end
        end

        assign pin_sync[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/gpio_reg_store.sv
// Storage for the writable registers: output latch, polarity and direction.
// Assumes only bits below NUM_PINS are stored; writes to the pin register are dropped.
module gpio_reg_store
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int REG_W = 8
) (
    input logic clk,
    input logic rst_n,
    input reg_idx_e reg_idx,
    input logic wr_en,
    input logic [REG_W-1:0] wr_data,
    output logic [NUM_PINS-1:0] latch_q,
    output logic [NUM_PINS-1:0] polar_q,
    output logic [NUM_PINS-1:0] dir_q
);

    // Load the addressed register on a write strobe; reset to defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
            polar_q <= '0;
            dir_q <= '1;
        end else if (wr_en) begin
            case (reg_idx)
                IDX_LATCH: latch_q <= wr_data[NUM_PINS-1:0];
                IDX_POLAR: polar_q <= wr_data[NUM_PINS-1:0];
                IDX_DIR: dir_q <= wr_data[NUM_PINS-1:0];
                default: ;
            endcase
        end
    end

    p_reset_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (latch_q == '1 && polar_q == '0 && dir_q == '1));

    p_pins_wr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == IDX_PINS) |=>
            ($stable(latch_q) && $stable(polar_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_read_path.sv
// Read path: selects and registers the addressed register's byte on a read request.
// Assumes NUM_PINS < REG_W; the unused upper bits read as constants.
// The pin register snapshot is taken on the request edge, so the nibble is coherent.
module gpio_read_path
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int REG_W = 8
) (
    input logic clk,
    input logic rst_n,
    input reg_idx_e reg_idx,
    input logic rd_req,
    input logic [NUM_PINS-1:0] pin_sync,
    input logic [NUM_PINS-1:0] latch_q,
    input logic [NUM_PINS-1:0] polar_q,
    input logic [NUM_PINS-1:0] dir_q,
    output logic [REG_W-1:0] rd_data
);

    localparam int FILL_W = REG_W - NUM_PINS;
    localparam logic [FILL_W-1:0] FILL_ONES = '1;
    localparam logic [FILL_W-1:0] FILL_ZERO = '0;

    logic [REG_W-1:0] rd_next;
    logic [REG_W-1:0] rd_q;

    // Choose the byte for the addressed register.
    always_comb begin
        case (reg_idx)
            IDX_PINS: rd_next = {FILL_ONES, pin_sync ^ polar_q};
            IDX_LATCH: rd_next = {FILL_ONES, latch_q};
            IDX_POLAR: rd_next = {FILL_ZERO, polar_q};
            default: rd_next = {FILL_ONES, dir_q};
        endcase
    end

    // Capture the selected byte only when a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_req) begin
            rd_q <= rd_next;
        end
    end

    assign rd_data = rd_q;

    p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && reg_idx != IDX_POLAR) |=> (rd_data[REG_W-1:NUM_PINS] == FILL_ONES));

    p_upper_polar_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && reg_idx == IDX_POLAR) |=> (rd_data[REG_W-1:NUM_PINS] == FILL_ZERO));

    p_latch_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && reg_idx == IDX_LATCH) |=> (rd_data[NUM_PINS-1:0] == $past(latch_q)));

    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && $past(rst_n)) |=> $stable(rd_data));

endmodule

// File: rtl/gpio_port_bank.sv
// Top: GPIO port register bank with polarity-inverted input reads.
// Assumes a synchronous active-low reset; pin_oe is gated low while reset is held.
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int REG_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic [1:0] reg_idx,
    input logic wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic rd_req,
    output logic [REG_W-1:0] rd_data,
    input logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    reg_idx_e idx;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] latch_q;
    logic [NUM_PINS-1:0] polar_q;
    logic [NUM_PINS-1:0] dir_q;

    assign idx = reg_idx_e'(reg_idx);

    gpio_pin_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_in), .pin_sync(pin_sync)
    );

    gpio_reg_store #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .reg_idx(idx), .wr_en(wr_en), .wr_data(wr_data),
        .latch_q(latch_q), .polar_q(polar_q), .dir_q(dir_q)
    );

    gpio_read_path #(.NUM_PINS(NUM_PINS), .REG_W(REG_W)) u_read (
        .clk(clk), .rst_n(rst_n), .reg_idx(idx), .rd_req(rd_req),
        .pin_sync(pin_sync), .latch_q(latch_q), .polar_q(polar_q), .dir_q(dir_q),
        .rd_data(rd_data)
    );

    // Drive pins configured as outputs; release all pins while in reset.
    always_comb begin
        pin_oe = rst_n ? ~dir_q : '0;
        pin_out = latch_q & pin_oe;
    end

    // Release every pin driver while reset is asserted.
    always_comb begin
        if (!rst_n) begin
            p_oe_off_in_reset_r2: assert (pin_oe == '0);
        end
    end

    p_oe_follows_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_DIR) |=> (pin_oe == ~$past(wr_data[NUM_PINS-1:0])));

    p_released_pin_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_LATCH) |=>
            (pin_out == ($past(wr_data[NUM_PINS-1:0]) & ~dir_q)));

endmodule

// File: tb/gpio_port_bank_test.sv
// Self-checking bench: exhaustive pin-drive and input-polarity sweeps plus directed cases.
module gpio_port_bank_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] reg_idx = 2'd0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic rd_req = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] pin_in = 4'hA;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_bank uut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
        .rd_req(rd_req), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge after the write edge.
    task automatic write_reg(input logic [1:0] idx, input logic [7:0] data);
        reg_idx = idx;
        wr_data = data;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Called at a negedge; samples rd_data at the negedge after the request edge.
    task automatic read_reg(input logic [1:0] idx, output logic [7:0] data);
        reg_idx = idx;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        data = rd_data;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] held;

        // R2: drivers released while reset is held
        check("R2 oe before first edge", {4'h0, pin_oe}, 8'h00);
        repeat (3) @(negedge clk);
        check("R2 oe during reset", {4'h0, pin_oe}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: defaults after reset
        check("R1 oe after reset", {4'h0, pin_oe}, 8'h00);
        read_reg(2'd1, rd); check("R1 latch default", rd, 8'hFF);
        read_reg(2'd2, rd); check("R1 polarity default", rd, 8'h00);
        read_reg(2'd3, rd); check("R1 direction default", rd, 8'hFF);
        read_reg(2'd0, rd); check("R1 pin read default", rd, 8'hFA);

        // R3: exhaustive direction x latch sweep on the pin side
        for (int d = 0; d < 16; d++) begin
            for (int l = 0; l < 16; l++) begin
                write_reg(2'd3, 8'(d));
                write_reg(2'd1, 8'(l));
                check("R3 pin_oe", {4'h0, pin_oe}, {4'h0, ~4'(d)});
                check("R3 pin_out", {4'h0, pin_out}, {4'h0, 4'(l) & ~4'(d)});
            end
        end

        // R4: exhaustive pin level x polarity sweep of the input read
        write_reg(2'd3, 8'hFF);
        for (int p = 0; p < 16; p++) begin
            for (int m = 0; m < 16; m++) begin
                pin_in = 4'(p);
                write_reg(2'd2, 8'(m));
                @(negedge clk);
                read_reg(2'd0, rd);
                check("R4 pin read xor polarity", rd, {4'hF, 4'(p) ^ 4'(m)});
            end
        end
        write_reg(2'd2, 8'h00);

        // R5 and R7: all pins as outputs, latch opposite to pin levels
        write_reg(2'd3, 8'h00);
        write_reg(2'd1, 8'h05);
        pin_in = 4'hA;
        repeat (2) @(negedge clk);
        read_reg(2'd1, rd); check("R7 latch read is flop value", rd, 8'hF5);
        read_reg(2'd0, rd); check("R5 pin read on output pins", rd, 8'hFA);

        // R6: writes to the pin register are dropped
        write_reg(2'd2, 8'h03);
        write_reg(2'd0, 8'h00);
        write_reg(2'd0, 8'hFF);
        read_reg(2'd1, rd); check("R6 latch after index 0 write", rd, 8'hF5);
        read_reg(2'd2, rd); check("R6 polarity after index 0 write", rd, 8'h03);
        read_reg(2'd3, rd); check("R6 direction after index 0 write", rd, 8'hF0);
        read_reg(2'd0, rd); check("R6 pin read after index 0 write", rd, 8'hF9);
        check("R6 pins unchanged", {pin_oe, pin_out}, 8'hF5);

        // R8: upper nibble is constant per register
        write_reg(2'd1, 8'h00);
        read_reg(2'd1, rd); check("R8 latch upper ones", rd, 8'hF0);
        write_reg(2'd2, 8'hF0);
        read_reg(2'd2, rd); check("R8 polarity upper zeros", rd, 8'h00);
        write_reg(2'd2, 8'hFF);
        read_reg(2'd2, rd); check("R8 polarity upper zeros full", rd, 8'h0F);
        write_reg(2'd3, 8'h0F);
        read_reg(2'd3, rd); check("R8 direction upper ones", rd, 8'hFF);
        read_reg(2'd0, rd); check("R8 pin read upper ones", rd, 8'hF5);

        // R9: rd_data holds without a request while pins move
        held = rd_data;
        for (int k = 0; k < 6; k++) begin
            pin_in = 4'(k * 5);
            @(negedge clk);
            check("R9 read data held", rd_data, held);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule